// File: doc/BRIEF.md
# Cursor Overlay with Frame-Aligned Shadow Registers

This block places a small cursor image on top of a live video pixel stream. The image is held in an internal memory of 32-bit words and loaded through a plain address/data write port. Each pixel that falls inside the cursor rectangle is alpha-blended with the background pixel. Outside the rectangle, or when the cursor is off, the background passes through unchanged. Data-enable and both syncs are delayed so that they stay aligned with the colour data.

Position, size and enable are written into shadow registers. A two-state machine (`SH_CLEAN`: shadow equals active; `SH_DIRTY`: an accepted write has not yet been applied) copies them to the active set only when a frame-done pulse arrives. The transitions are: CLEAN→DIRTY on an accepted write, DIRTY→CLEAN on frame-done with no write in the same cycle, and DIRTY→DIRTY on frame-done together with a write. The host does the clipping, so the rectangle always lies in screen space. In interlaced output each field shows every other cursor line.

Top module: `cursor_overlay`

## Requirements
- R1: After reset the active cursor is disabled, the active position and size are zero, and `out_rgb`, `out_de`, `out_hs`, `out_vs` are all zero.
- R2: `out_de`, `out_hs`, `out_vs` and `out_rgb` follow the matching inputs exactly two clock cycles later.
- R3: When `in_de` is low, when the cursor is disabled, or when the pixel (`pix_x`,`pix_y`) lies outside the rectangle x in [X, X+W) and y in [Y, Y+H), `out_rgb` equals `in_rgb`.
- R4: A cursor memory word holds alpha in bits 31:24, blue in 23:16, green in 15:8 and red in 7:0. `in_rgb` and `out_rgb` carry red in 23:16, green in 15:8 and blue in 7:0.
- R5: Inside the rectangle each output channel is (A*C + (255-A)*B)/255, rounded down. A is the alpha, C the cursor channel and B the background channel. So alpha 255 gives the cursor colour and alpha 0 gives the background.
- R6: Cursor pixels are stored row-major with a row stride equal to the active width: word address = row*W + column, relative to the rectangle's top-left corner.
- R7: `cfg_sel` 0 writes the position (y in 31:16, x in 15:0). 1 writes the size (height in 31:16, width in 15:0). 2 writes the enable (bit 0). 3 is ignored. Writes land in shadow registers and affect the output only after the next `frame_done` pulse.
- R8: A size write with width > 64, height > 64, or both width and height > 32 is rejected and leaves the shadow size unchanged. 64x32 and 32x64 are accepted.
- R9: The cursor shows nothing when the active width is zero or the effective height is zero.
- R10: With `interlace` high, the effective y position is Y/2 and the effective height is H/2. Field line n of the rectangle shows cursor row 2n + `field`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register select: 0 position, 1 size, 2 enable |
| cfg_wdata | input | 32 | Register write data |
| mem_we | input | 1 | Cursor memory write strobe |
| mem_addr | input | 11 | Cursor memory word address |
| mem_wdata | input | 32 | Cursor memory word, alpha/blue/green/red from high byte down |
| frame_done | input | 1 | Frame-done pulse; applies shadow registers |
| interlace | input | 1 | Interlaced output mode |
| field | input | 1 | Current field parity in interlaced mode |
| pix_x | input | 16 | Column of the incoming pixel |
| pix_y | input | 16 | Line of the incoming pixel (field line when interlaced) |
| in_rgb | input | 24 | Background pixel, red/green/blue from high byte down |
| in_de | input | 1 | Incoming data enable |
| in_hs | input | 1 | Incoming horizontal sync |
| in_vs | input | 1 | Incoming vertical sync |
| out_rgb | output | 24 | Blended pixel |
| out_de | output | 1 | Delayed data enable |
| out_hs | output | 1 | Delayed horizontal sync |
| out_vs | output | 1 | Delayed vertical sync |

## Verification
The embedded checks assume that `pix_x`, `pix_y`, `in_rgb` and the sync inputs are driven with known values from reset onward. They also assume that `frame_done` is a single-cycle pulse. The bench holds every input at zero during reset and drives each one at the falling edge, so these conditions always hold. The checks further assume that the cursor memory words being read were written first. The bench fills all 2048 words before it enables the cursor, and it keeps every hit address within the written range.

// File: rtl/cursor_pkg.sv
package cursor_pkg;
    localparam int COORD_W = 16;

    typedef enum logic [1:0] {
        SEL_POS  = 2'd0,
        SEL_SIZE = 2'd1,
        SEL_CTRL = 2'd2,
        SEL_NONE = 2'd3
    } cfg_sel_e;

    typedef enum logic {
        SH_CLEAN = 1'b0,
        SH_DIRTY = 1'b1
    } shadow_state_e;

    typedef struct packed {
        logic [COORD_W-1:0] y;
        logic [COORD_W-1:0] x;
        logic [COORD_W-1:0] h;
        logic [COORD_W-1:0] w;
        logic               en;
    } cursor_cfg_t;
endpackage

// File: rtl/cursor_shadow.sv
module cursor_shadow
    import cursor_pkg::*;
#(
    parameter int MAX_DIM   = 64,
    parameter int SMALL_DIM = 32
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cfg_we,
    input  logic [1:0]  cfg_sel,
    input  logic [31:0] cfg_wdata,
    input  logic        frame_done,
    output cursor_cfg_t active
);
    shadow_state_e state_q, state_d;
    cursor_cfg_t   shadow_q, active_q;
    logic          size_ok, wr_ok, commit;
    logic [COORD_W-1:0] req_w, req_h;

    assign req_w   = cfg_wdata[COORD_W-1:0];
    assign req_h   = cfg_wdata[31:32-COORD_W];
    assign size_ok = (req_w <= COORD_W'(MAX_DIM)) && (req_h <= COORD_W'(MAX_DIM)) &&
                     !((req_w > COORD_W'(SMALL_DIM)) && (req_h > COORD_W'(SMALL_DIM)));
    assign wr_ok   = cfg_we && (cfg_sel != SEL_NONE) && (cfg_sel != SEL_SIZE || size_ok);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= SH_CLEAN;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        commit  = 1'b0;
        unique case (state_q)
            SH_CLEAN: if (wr_ok) state_d = SH_DIRTY;
            SH_DIRTY: begin
                commit = frame_done;
                if (frame_done && !wr_ok) state_d = SH_CLEAN;
            end
            default: state_d = SH_CLEAN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shadow_q <= '0;
            active_q <= '0;
        end else begin
            if (commit) active_q <= shadow_q;
            if (wr_ok) begin
                unique case (cfg_sel)
                    SEL_POS:  begin
                        shadow_q.x <= cfg_wdata[COORD_W-1:0];
                        shadow_q.y <= cfg_wdata[31:32-COORD_W];
                    end
                    SEL_SIZE: begin
                        shadow_q.w <= req_w;
                        shadow_q.h <= req_h;
                    end
                    SEL_CTRL: shadow_q.en <= cfg_wdata[0];
                    default:  ;
                endcase
            end
        end
    end

    assign active = active_q;

    a_r7_hold_between_frames: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_done |=> $stable(active_q))
        else $error("active registers changed without frame_done");

    a_r8_reject_bad_size: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_sel == SEL_SIZE && !size_ok) |=> ($stable(shadow_q.w) && $stable(shadow_q.h)))
        else $error("illegal size reached the shadow register");
endmodule

// File: rtl/cursor_mem.sv
module cursor_mem #(
    parameter int DEPTH  = 2048,
    parameter int DATA_W = 32,
    localparam int ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] store [DEPTH];

    always_ff @(posedge clk) begin
        if (we) store[waddr] <= wdata;
        rdata <= store[raddr];
    end
endmodule

// File: rtl/cursor_blend.sv
module cursor_blend #(
    parameter int CH_W  = 8,
    parameter int N_CH  = 3,
    localparam int PIX_W = CH_W * N_CH,
    localparam int SUM_W = 2 * CH_W + 1
) (
    input  logic [CH_W-1:0]  alpha,
    input  logic [PIX_W-1:0] fg,
    input  logic [PIX_W-1:0] bg,
    input  logic             hit,
    output logic [PIX_W-1:0] mix
);
    localparam logic [CH_W-1:0] FULL = {CH_W{1'b1}};

    for (genvar c = 0; c < N_CH; c++) begin : g_ch
        logic [SUM_W-1:0] acc;
        logic [CH_W-1:0]  res;
        assign acc = SUM_W'(alpha * fg[c*CH_W +: CH_W]) +
                     SUM_W'((FULL - alpha) * bg[c*CH_W +: CH_W]);
        assign res = CH_W'(acc / SUM_W'(FULL));
        assign mix[c*CH_W +: CH_W] = hit ? res : bg[c*CH_W +: CH_W];

        always_comb begin
            if (hit && alpha == FULL)
                a_r5_opaque: assert (res == fg[c*CH_W +: CH_W])
                    else $error("opaque pixel not equal to cursor");
            if (hit && alpha == '0)
                a_r5_clear: assert (res == bg[c*CH_W +: CH_W])
                    else $error("clear pixel not equal to background");
        end
    end
endmodule

// File: rtl/cursor_overlay.sv
module cursor_overlay
    import cursor_pkg::*;
#(
    parameter int MAX_DIM   = 64,
    parameter int SMALL_DIM = 32,
    localparam int DEPTH    = MAX_DIM * SMALL_DIM,
    localparam int ADDR_W   = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [1:0]        cfg_sel,
    input  logic [31:0]       cfg_wdata,
    input  logic              mem_we,
    input  logic [ADDR_W-1:0] mem_addr,
    input  logic [31:0]       mem_wdata,
    input  logic              frame_done,
    input  logic              interlace,
    input  logic              field,
    input  logic [15:0]       pix_x,
    input  logic [15:0]       pix_y,
    input  logic [23:0]       in_rgb,
    input  logic              in_de,
    input  logic              in_hs,
    input  logic              in_vs,
    output logic [23:0]       out_rgb,
    output logic              out_de,
    output logic              out_hs,
    output logic              out_vs
);
    cursor_cfg_t        act;
    logic [COORD_W-1:0] eff_y, eff_h, dx, dy, row;
    logic [COORD_W:0]   x_end, y_end;
    logic               hit_s0, hit_s1;
    logic [ADDR_W-1:0]  rd_addr;
    logic [31:0]        word_s1;
    logic [23:0]        bg_s1, fg_s1, mix;
    logic [2:0]         sync_s1;
    logic [1:0]         warm_q;

    cursor_shadow #(.MAX_DIM(MAX_DIM), .SMALL_DIM(SMALL_DIM)) u_shadow (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .frame_done(frame_done), .active(act)
    );

    // Rectangle test, halved vertically in interlaced mode
    assign eff_y = interlace ? (act.y >> 1) : act.y;
    assign eff_h = interlace ? (act.h >> 1) : act.h;
    assign x_end = {1'b0, act.x} + {1'b0, act.w};
    assign y_end = {1'b0, eff_y} + {1'b0, eff_h};
    assign hit_s0 = act.en && in_de && (act.w != '0) && (eff_h != '0) &&
                    (pix_x >= act.x) && ({1'b0, pix_x} < x_end) &&
                    (pix_y >= eff_y) && ({1'b0, pix_y} < y_end);
    assign dx  = pix_x - act.x;
    assign dy  = pix_y - eff_y;
    assign row = interlace ? {dy[COORD_W-2:0], field} : dy;
    assign rd_addr = ADDR_W'(row * act.w + dx);

    cursor_mem #(.DEPTH(DEPTH), .DATA_W(32)) u_mem (
        .clk(clk), .we(mem_we), .waddr(mem_addr), .wdata(mem_wdata),
        .raddr(rd_addr), .rdata(word_s1)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hit_s1  <= 1'b0;
            bg_s1   <= '0;
            sync_s1 <= '0;
            out_rgb <= '0;
            out_de  <= 1'b0;
            out_hs  <= 1'b0;
            out_vs  <= 1'b0;
            warm_q  <= '0;
        end else begin
            hit_s1  <= hit_s0;
            bg_s1   <= in_rgb;
            sync_s1 <= {in_de, in_hs, in_vs};
            out_rgb <= mix;
            {out_de, out_hs, out_vs} <= sync_s1;
            if (warm_q != 2'd2) warm_q <= warm_q + 2'd1;
        end
    end

    // Memory word is A,B,G,R from the top byte; stream is R,G,B
    assign fg_s1 = {word_s1[7:0], word_s1[15:8], word_s1[23:16]};

    cursor_blend #(.CH_W(8), .N_CH(3)) u_blend (
        .alpha(word_s1[31:24]), .fg(fg_s1), .bg(bg_s1), .hit(hit_s1), .mix(mix)
    );

    a_r2_sync_latency: assert property (@(posedge clk) disable iff (!rst_n)
        (warm_q == 2'd2) |-> ({out_de, out_hs, out_vs} == $past({in_de, in_hs, in_vs}, 2)))
        else $error("sync path latency is not two cycles");

    a_r3_pass_outside: assert property (@(posedge clk) disable iff (!rst_n)
        !hit_s1 |=> (out_rgb == $past(bg_s1)))
        else $error("background altered outside the cursor");

    a_r9_empty_no_hit: assert property (@(posedge clk) disable iff (!rst_n)
        (act.w == '0 || eff_h == '0) |=> !hit_s1)
        else $error("hit with empty cursor");
endmodule

// File: tb/cursor_overlay_bench.sv
module cursor_overlay_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_sel = 2'd0;
    logic [31:0] cfg_wdata = '0;
    logic        mem_we = 1'b0;
    logic [10:0] mem_addr = '0;
    logic [31:0] mem_wdata = '0;
    logic        frame_done = 1'b0;
    logic        interlace = 1'b0;
    logic        field = 1'b0;
    logic [15:0] pix_x = '0;
    logic [15:0] pix_y = '0;
    logic [23:0] in_rgb = '0;
    logic        in_de = 1'b0;
    logic        in_hs = 1'b0;
    logic        in_vs = 1'b0;
    logic [23:0] out_rgb;
    logic        out_de, out_hs, out_vs;

    logic [31:0] tb_mem [2048];
    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    cursor_overlay u_cursor_overlay (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .frame_done(frame_done), .interlace(interlace),
        .field(field), .pix_x(pix_x), .pix_y(pix_y), .in_rgb(in_rgb),
        .in_de(in_de), .in_hs(in_hs), .in_vs(in_vs), .out_rgb(out_rgb),
        .out_de(out_de), .out_hs(out_hs), .out_vs(out_vs)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] mixch(input int a, input int c, input int b);
        return 8'((a * c + (255 - a) * b) / 255);
    endfunction

    function automatic logic [23:0] expect_px(input int addr, input logic [23:0] bg);
        logic [31:0] w = tb_mem[addr];
        return {mixch(w[31:24], w[7:0],   bg[23:16]),
                mixch(w[31:24], w[15:8],  bg[15:8]),
                mixch(w[31:24], w[23:16], bg[7:0])};
    endfunction

    task automatic cfg_write(input logic [1:0] sel, input logic [31:0] d);
        @(negedge clk); cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
        @(negedge clk); cfg_we = 1'b0;
    endtask

    task automatic commit();
        @(negedge clk); frame_done = 1'b1;
        @(negedge clk); frame_done = 1'b0;
    endtask

    // addr < 0 means the pixel must pass through unchanged
    task automatic probe(input string tag, input int x, input int y, input logic fld, input int addr);
        logic [23:0] bg = 24'h3C_96_E1;
        @(negedge clk); pix_x = 16'(x); pix_y = 16'(y); field = fld; in_rgb = bg; in_de = 1'b1;
        @(negedge clk); in_de = 1'b0; in_rgb = 24'h0;
        @(negedge clk);
        check(tag, {8'h0, out_rgb}, {8'h0, (addr < 0) ? bg : expect_px(addr, bg)});
    endtask

    task automatic t_reset();
        check("R1 reset out_rgb", {8'h0, out_rgb}, 32'h0);
        check("R1 reset syncs", {29'h0, out_de, out_hs, out_vs}, 32'h0);
        probe("R1 cursor off after reset", 0, 0, 1'b0, -1);
    endtask

    task automatic t_load();
        for (int a = 0; a < 2048; a++) begin
            logic [31:0] w = {8'(a * 7 + 3), 8'(a * 13 + 9), 8'(a * 29 + 1), 8'(a * 3 + 5)};
            if (a == 0) w[31:24] = 8'hFF;
            if (a == 7) w[31:24] = 8'h00;
            tb_mem[a] = w;
            @(negedge clk); mem_we = 1'b1; mem_addr = 11'(a); mem_wdata = w;
        end
        @(negedge clk); mem_we = 1'b0;
    endtask

    task automatic t_shadow();
        cfg_write(2'd0, {16'd20, 16'd10});
        cfg_write(2'd1, {16'd4, 16'd8});
        cfg_write(2'd2, 32'h1);
        cfg_write(2'd3, 32'hFFFF_FFFF);
        probe("R7 no effect before frame_done", 10, 20, 1'b0, -1);
        commit();
        probe("R7 applied after frame_done", 10, 20, 1'b0, 0);
    endtask

    task automatic t_blend();
        probe("R5 R4 opaque corner", 10, 20, 1'b0, 0);
        probe("R5 clear pixel", 17, 20, 1'b0, 7);
        probe("R6 second row stride", 10, 21, 1'b0, 8);
        probe("R6 R4 interior blend", 13, 23, 1'b0, 27);
        probe("R3 right of rect", 18, 20, 1'b0, -1);
        probe("R3 left of rect", 9, 20, 1'b0, -1);
        probe("R3 below rect", 10, 24, 1'b0, -1);
        probe("R3 above rect", 10, 19, 1'b0, -1);
    endtask

    task automatic t_latency();
        @(negedge clk); in_hs = 1'b1; in_vs = 1'b1;
        @(negedge clk); in_hs = 1'b0; in_vs = 1'b0;
        check("R2 one cycle not yet", {30'h0, out_hs, out_vs}, 32'h0);
        @(negedge clk);
        check("R2 two cycles", {30'h0, out_hs, out_vs}, 32'h3);
        @(negedge clk);
        check("R2 pulse width", {30'h0, out_hs, out_vs}, 32'h0);
        // data enable low inside the rectangle: passthrough
        @(negedge clk); pix_x = 16'd10; pix_y = 16'd20; in_rgb = 24'h112233; in_de = 1'b0;
        @(negedge clk); in_rgb = 24'h0;
        @(negedge clk);
        check("R3 de low passthrough", {8'h0, out_rgb}, 32'h112233);
    endtask

    task automatic t_reject();
        cfg_write(2'd1, {16'd33, 16'd33});
        commit();
        probe("R8 33x33 rejected", 18, 20, 1'b0, -1);
        cfg_write(2'd1, {16'd1, 16'd65});
        commit();
        probe("R8 65x1 rejected", 18, 20, 1'b0, -1);
        probe("R8 old size kept", 17, 23, 1'b0, 31);
        cfg_write(2'd1, {16'd32, 16'd64});
        commit();
        probe("R8 R6 64x32 accepted", 73, 51, 1'b0, 2047);
        cfg_write(2'd1, {16'd64, 16'd32});
        commit();
        probe("R8 R6 32x64 accepted", 41, 83, 1'b0, 2047);
    endtask

    task automatic t_empty();
        cfg_write(2'd1, {16'd4, 16'd0});
        commit();
        probe("R9 zero width", 10, 20, 1'b0, -1);
        cfg_write(2'd1, {16'd0, 16'd8});
        commit();
        probe("R9 zero height", 10, 20, 1'b0, -1);
    endtask

    task automatic t_interlace();
        cfg_write(2'd1, {16'd4, 16'd8});
        commit();
        interlace = 1'b1;
        probe("R10 odd field row 1", 10, 10, 1'b1, 8);
        probe("R10 even field row 2", 10, 11, 1'b0, 16);
        probe("R10 halved height", 10, 12, 1'b0, -1);
        cfg_write(2'd1, {16'd1, 16'd8});
        commit();
        probe("R9 R10 height halves to zero", 10, 10, 1'b0, -1);
        interlace = 1'b0;
        probe("R10 progressive single row", 10, 20, 1'b0, 0);
    endtask

    task automatic t_disable();
        cfg_write(2'd2, 32'h0);
        probe("R7 enable clear pending", 10, 20, 1'b0, 0);
        commit();
        probe("R3 disabled passthrough", 10, 20, 1'b0, -1);
    endtask

    task automatic report();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_load();
        t_shadow();
        t_blend();
        t_latency();
        t_reject();
        t_empty();
        t_interlace();
        t_disable();
        done = 1'b1;
        report();
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            report();
        end
    end
endmodule